// File: doc/BRIEF.md
# Masked Input-Port Interrupt Controller

This block collects interrupt events from a 4-bit asynchronous input port and from three periodic timer ticks (2 Hz, 8 Hz, 32 Hz). It raises one interrupt request towards a processor. Each port pin and each timer source has its own enable mask bit. The four port pins share one latched event flag. Each timer source latches its own flag.

Port pins first pass through a two-flop synchronizer. Each synchronized pin is then ANDed with its mask bit. A rising edge of that gated signal sets the shared port flag. Because the edge is taken after the gating, turning a mask on while its pin is already high counts as a new event.

The processor side works as follows:
- It writes and reads back the mask registers, using one write strobe per register.
- It reads the flag register. The read returns the current flags and clears them one cycle later.
- It supplies a global interrupt-enable level, which qualifies the request.

Top module: `kport_irq_ctrl`

## Requirements
- R1: After reset, `port_mask_o`, `tmr_mask_o` and `flags_o` are all zero, and `irq_o` is 0.
- R2: A cycle with `port_mask_we_i` (or `tmr_mask_we_i`) high loads the write data into that mask register at the clock edge, and the new value is visible on `port_mask_o` (or `tmr_mask_o`) after that edge. Without the strobe, the register holds its value.
- R3: When a port pin rises while its mask bit is 1, the port flag `flags_o[0]` goes to 1 after the third rising clock edge following the pin change: two synchronizer edges, then one flag edge.
- R4: A port pin that stays high, with its mask unchanged, does not set the port flag again after the flag is cleared.
- R5: Changing a mask bit from 0 to 1 while its synchronized pin is high sets `flags_o[0]` one clock edge after the mask write takes effect.
- R6: Setting a mask bit while its pin is low does not set the port flag. A later real low-to-high change of that pin does set it.
- R7: A pin whose mask bit is 0 never sets the port flag, whatever it does.
- R8: Flag bits `flags_o[1]`, `flags_o[2]` and `flags_o[3]` belong to timer sources `tick_i[0]` (2 Hz), `tick_i[1]` (8 Hz) and `tick_i[2]` (32 Hz). A tick pulse sets its flag at the next clock edge only if the matching `tmr_mask_o` bit is 1.
- R9: A set flag stays set until the flags are read. A cycle with `flag_rd_i` high shows the current flags, and all flags are cleared at that cycle's clock edge.
- R10: When a set event and a read-clear reach the same flag at the same clock edge, the flag ends up set.
- R11: `irq_o` is 1 exactly when `gie_i` is 1 and at least one bit of `flags_o` is 1.
- R12: A port pin that is already high at reset release, with its mask at 0, causes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 4 | Asynchronous port pins |
| tick_i | input | 3 | Single-cycle timer ticks, bit 0 = 2 Hz, bit 1 = 8 Hz, bit 2 = 32 Hz |
| gie_i | input | 1 | Global interrupt enable |
| port_mask_we_i | input | 1 | Write strobe for the port mask |
| port_mask_wdata_i | input | 4 | Port mask write data |
| tmr_mask_we_i | input | 1 | Write strobe for the timer mask |
| tmr_mask_wdata_i | input | 3 | Timer mask write data |
| flag_rd_i | input | 1 | Flag register read; clears all flags at this edge |
| port_mask_o | output | 4 | Port mask readback |
| tmr_mask_o | output | 3 | Timer mask readback |
| flags_o | output | 4 | Bit 0 = port flag, bits 3:1 = timer flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs:
- each `tick_i` bit is a synchronous pulse that is already aligned to `clk_i`;
- the write strobes and `flag_rd_i` are synchronous to `clk_i`;
- `port_i` may change at any time, since it only reaches logic through the synchronizer.

The stimulus drives every input a quarter period after the rising edge, so the model and the design see the same stable values. Port pins are held for at least three edges before the outcome is judged, so every expected value accounts for the full synchronizer delay.

// File: rtl/kport_irq_pkg.sv
package kport_irq_pkg;
  localparam int unsigned PORT_W      = 4;
  localparam int unsigned TMR_N       = 3;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned PORT_FLAG   = 0;
endpackage

// File: rtl/kport_sync.sv
module kport_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= '0;
    else         q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[k] <= '0;
      else         q[k] <= q[k-1];
    end
    // R3: each stage adds exactly one cycle
    a_r3_stage_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
      q[k] == $past(q[k-1]));
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/kport_edge_flag.sv
module kport_edge_flag #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         flag_o
);
  logic [W-1:0] gated;
  logic [W-1:0] prev_q;
  logic         hit;
  logic         flag_q;

  // edge taken after gating: enabling a high pin is an event
  assign gated = sync_i & mask_i;
  assign hit   = |(gated & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= gated;
      flag_q <= hit | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && clr_i |=> flag_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit |=> !flag_q);
  a_r7_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(|mask_i));
  a_r4_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(|(sync_i & mask_i)));
endmodule

// File: rtl/kport_tmr_flags.sv
module kport_tmr_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] tick_i,
  input  logic [N-1:0] mask_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= (tick_i[i] & mask_i[i]) | (flag_q[i] & ~clr_i);
    end
    // R8: a timer flag only rises from a masked-in tick
    a_r8_tick_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_q[i]) |-> $past(tick_i[i] && mask_i[i]));
    a_r9_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q[i] && !clr_i |=> flag_q[i]);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/kport_irq_ctrl.sv
module kport_irq_ctrl
  import kport_irq_pkg::*;
#(
  parameter int unsigned P_W   = PORT_W,
  parameter int unsigned T_N   = TMR_N,
  parameter int unsigned SYNC  = SYNC_STAGES,
  localparam int unsigned FLAG_W = T_N + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [P_W-1:0]    port_i,
  input  logic [T_N-1:0]    tick_i,
  input  logic              gie_i,
  input  logic              port_mask_we_i,
  input  logic [P_W-1:0]    port_mask_wdata_i,
  input  logic              tmr_mask_we_i,
  input  logic [T_N-1:0]    tmr_mask_wdata_i,
  input  logic              flag_rd_i,
  output logic [P_W-1:0]    port_mask_o,
  output logic [T_N-1:0]    tmr_mask_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [P_W-1:0] port_mask_q;
  logic [T_N-1:0] tmr_mask_q;
  logic [P_W-1:0] port_sync;
  logic           port_flag;
  logic [T_N-1:0] tmr_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_mask_q <= '0;
      tmr_mask_q  <= '0;
    end else begin
      if (port_mask_we_i) port_mask_q <= port_mask_wdata_i;
      if (tmr_mask_we_i)  tmr_mask_q  <= tmr_mask_wdata_i;
    end
  end

  kport_sync #(.W(P_W), .STAGES(SYNC)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (port_i),
    .q_o    (port_sync)
  );

  kport_edge_flag #(.W(P_W)) u_port_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (port_sync),
    .mask_i (port_mask_q),
    .clr_i  (flag_rd_i),
    .flag_o (port_flag)
  );

  kport_tmr_flags #(.N(T_N)) u_tmr_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .mask_i  (tmr_mask_q),
    .clr_i   (flag_rd_i),
    .flags_o (tmr_flag)
  );

  assign port_mask_o = port_mask_q;
  assign tmr_mask_o  = tmr_mask_q;
  assign flags_o     = {tmr_flag, port_flag};
  assign irq_o       = gie_i & (|flags_o);

  a_r2_port_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_mask_we_i |=> port_mask_o == $past(port_mask_wdata_i));
  a_r2_port_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_mask_we_i |=> $stable(port_mask_o));
  a_r2_tmr_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_mask_we_i |=> $stable(tmr_mask_o));
  a_r11_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i && flags_o != '0);
  a_r12_port_flag_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_mask_o == '0 && $past(port_mask_o) == '0 |-> !$rose(flags_o[PORT_FLAG]));
endmodule

// File: tb/kport_irq_ctrl_tb.sv
module kport_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] port = '0;
  logic [2:0] tick = '0;
  logic       gie = 1'b0;
  logic       pm_we = 1'b0;
  logic [3:0] pm_wd = '0;
  logic       tm_we = 1'b0;
  logic [2:0] tm_wd = '0;
  logic       rd = 1'b0;
  logic [3:0] pm_o;
  logic [2:0] tm_o;
  logic [3:0] fl_o;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kport_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port), .tick_i(tick), .gie_i(gie),
    .port_mask_we_i(pm_we), .port_mask_wdata_i(pm_wd),
    .tmr_mask_we_i(tm_we), .tmr_mask_wdata_i(tm_wd),
    .flag_rd_i(rd), .port_mask_o(pm_o), .tmr_mask_o(tm_o),
    .flags_o(fl_o), .irq_o(irq)
  );

  // behavioural reference model
  bit [3:0] syncq[$];
  bit [3:0] m_pm, m_fl, m_prev, m_gated;
  bit [2:0] m_tm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm = '0; m_tm = '0; m_fl = '0; m_prev = '0;
      syncq.delete(); syncq.push_back(4'h0); syncq.push_back(4'h0);
    end else begin
      m_gated = syncq[0] & m_pm;
      if (rd) m_fl = '0;
      if ((m_gated & ~m_prev) != 0) m_fl[0] = 1'b1;
      m_fl[3:1] = m_fl[3:1] | (tick & m_tm);
      m_prev = m_gated;
      void'(syncq.pop_front());
      syncq.push_back(port);
      if (pm_we) m_pm = pm_wd;
      if (tm_we) m_tm = tm_wd;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 port mask vs model", 32'(pm_o), 32'(m_pm));
      check("R2 timer mask vs model", 32'(tm_o), 32'(m_tm));
      check("R9 flags vs model", 32'(fl_o), 32'(m_fl));
      check("R11 irq vs model", 32'(irq), 32'(gie && m_fl != 0));
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #QTR;
  endtask

  task automatic wr_pm(logic [3:0] v);
    pm_we = 1'b1; pm_wd = v; step(1); pm_we = 1'b0;
  endtask

  task automatic rd_flags();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    port = 4'hF;  // R12: pins high across reset, masks zero
    step(3);
    rst_n = 1'b1;
    #1;
    check("R1 port mask reset", 32'(pm_o), 0);
    check("R1 timer mask reset", 32'(tm_o), 0);
    check("R1 flags reset", 32'(fl_o), 0);
    check("R1 irq reset", 32'(irq), 0);
    step(5);
    check("R12 no flag from high pin at reset", 32'(fl_o), 0);

    // R2 + R5: enable mask while pins held high
    wr_pm(4'b0101);
    check("R2 port mask readback", 32'(pm_o), 32'h5);
    check("R5 flag not yet set at write edge", 32'(fl_o[0]), 0);
    step(1);
    check("R5 flag set by mask enable on high pin", 32'(fl_o[0]), 1);
    tm_we = 1'b1; tm_wd = 3'b101; step(1); tm_we = 1'b0;
    check("R2 timer mask readback", 32'(tm_o), 32'h5);
    step(3);
    check("R9 flag sticky without read", 32'(fl_o[0]), 1);
    rd_flags();
    check("R9 flag cleared after read", 32'(fl_o), 0);
    step(4);
    check("R4 steady high pin does not retrigger", 32'(fl_o[0]), 0);

    // R7: masked pin rising
    port = 4'h0; step(4);
    port = 4'b0010; step(5);
    check("R7 masked pin ignored", 32'(fl_o[0]), 0);

    // R3: exact latency through synchronizer
    port = 4'b0011; step(2);
    check("R3 no flag after two edges", 32'(fl_o[0]), 0);
    step(1);
    check("R3 flag after third edge", 32'(fl_o[0]), 1);
    rd_flags();

    // R6: enable mask while pins low, then real rise
    port = 4'h0; step(4);
    wr_pm(4'b1111); step(3);
    check("R6 enabling on low pin no flag", 32'(fl_o[0]), 0);
    port = 4'b1000; step(3);
    check("R6 real rise sets flag", 32'(fl_o[0]), 1);
    rd_flags();
    check("R9 read clears port flag", 32'(fl_o), 0);

    // R8: ticks, timer mask 101
    tick = 3'b011; step(1); tick = '0;
    check("R8 only masked-in tick sets flag", 32'(fl_o), 32'h2);
    step(2);
    check("R9 timer flag sticky", 32'(fl_o), 32'h2);

    // R11
    gie = 1'b0; #1;
    check("R11 irq low when gie low", 32'(irq), 0);
    gie = 1'b1; #1;
    check("R11 irq high with gie and flag", 32'(irq), 1);

    // R10: tick on source 2 in the read cycle
    rd = 1'b1; tick = 3'b100; step(1); rd = 1'b0; tick = '0;
    check("R10 set wins over clear", 32'(fl_o), 32'h8);
    rd_flags();
    check("R11 irq low with no flags", 32'(irq), 0);

    // R10 on port flag: rise arriving on the read edge
    port = 4'b1001; step(2);
    rd = 1'b1; step(1); rd = 1'b0;
    check("R10 port set wins over clear", 32'(fl_o[0]), 1);
    rd_flags();
    step(2);
    finish_run();
  end
endmodule